// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Prioritizer

This block collects maskable interrupt requests from a fixed set of sources plus one non-maskable input, and chooses a single request to present to the processor as a vector number and a vector address. Each source has a fixed position in the vector table, and that position sets its default rank: a lower vector number ranks higher. On top of that order, each group of sources has one control-level bit. Sources in a group at level 1 are served before any source at level 0. Two global mask bits decide which levels can be accepted. The non-maskable input bypasses all masking and ranking.

Requests are latched as pending flags, so a request does not need to stay high. The chosen result is offered on a valid/ready style output: `irq_valid` with `irq_vec` and `irq_addr`, and `irq_ack` acting as ready. Back-pressure rules are as follows. While `irq_valid` is high and `irq_ack` is low, the offer stays exactly as it is, even if a higher-ranked request arrives. A cycle with both `irq_valid` and `irq_ack` high retires the offer and clears that source's pending flag. `irq_valid` is then low for at least one cycle before the next choice is offered. `irq_ack` has no effect while `irq_valid` is low.

A map-select input chooses between two vector assignments. The compact assignment covers only the lower sources. The extended assignment covers all sources.

Top module: `irq_vec_prio`

## Requirements
- R1: The vector address is always the vector number times four. Source i maps to vector 16+i when `ext_map`=0 and to vector 64+i when `ext_map`=1. The non-maskable input maps to vector 7, which is address 0x1C.
- R2: A rising edge on `nmi_in` makes a non-maskable request pending. It is offered ahead of every pending maskable request, whatever the state of the mask bits.
- R3: A pending source whose group level bit is 1 is offered before any pending source whose group level bit is 0.
- R4: Among eligible pending sources at the same level, the source with the lowest vector number is offered first.
- R5: Level bit g of `grp_level` applies to sources 2g and 2g+1 together. Within a group, the lower source always ranks first.
- R6: The mask bits control which maskable sources are accepted:
  - With `mask_i`=0, all maskable sources are accepted.
  - With `mask_i`=1 and `mask_ui`=0, only level-1 sources are accepted.
  - With both bits set to 1, no maskable source is accepted.
- R7: A masked request stays pending. It becomes eligible for selection in the cycle after the mask is lifted.
- R8: The offer is registered. While `irq_valid`=1 and `irq_ack`=0, the valid flag, vector and address hold steady. An acknowledge retires the offer and drops `irq_valid` in the next cycle. `irq_ack` with `irq_valid`=0 is ignored.
- R9: Source index 9 is a reserved slot and never produces a request.
- R10: When `ext_map`=0, sources 12 to 15 have no vector and their requests are ignored.
- R11: After reset, `irq_valid` is 0, `irq_vec` and `irq_addr` are 0, and nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 16 | Request strobes, one per maskable source |
| nmi_in | input | 1 | Non-maskable request, taken on its rising edge |
| grp_level | input | 8 | Control level bit per group of two sources |
| mask_i | input | 1 | Primary mask bit |
| mask_ui | input | 1 | Secondary mask bit, used only when `mask_i`=1 |
| ext_map | input | 1 | 0 selects the compact vector assignment, 1 selects the extended one |
| irq_ack | input | 1 | Ready: retires the current offer |
| irq_valid | output | 1 | An offer is present |
| irq_vec | output | 8 | Offered vector number |
| irq_addr | output | 10 | Offered vector address |

## Verification
The hardest situation to reach is one where several requests are pending at once and the ranking between them is decided only at the moment a mask is lifted. To get there, the stimulus first closes both masks and strobes a chosen set of sources. It then checks that nothing is offered, sets the group levels, and opens the masks one step at a time. The offers that follow then reveal the full ordering by level and by vector number. A further stimulus withholds the acknowledge while a non-maskable edge arrives, to show that an offer already on the output cannot be pre-empted.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_NMI  = 2'd1,
    SEL_SRC  = 2'd2
  } sel_kind_t;

  // Eligibility of a source slot under the current map selection.
  function automatic logic slot_live(input int idx, input logic ext,
                                     input int leg_cnt, input logic rsv);
    return !rsv && (ext || (idx < leg_cnt));
  endfunction

endpackage

// File: rtl/ivp_pend.sv
module ivp_pend #(
  parameter int NUM_SRC = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req,
  input  logic [NUM_SRC-1:0] src_en,
  input  logic               nmi_in,
  input  logic [NUM_SRC-1:0] clr_src,
  input  logic               clr_nmi,
  output logic [NUM_SRC-1:0] pend,
  output logic               nmi_pend
);

  logic nmi_q;
  logic nmi_rise;

  assign nmi_rise = nmi_in & ~nmi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend     <= '0;
      nmi_q    <= 1'b0;
      nmi_pend <= 1'b0;
    end else begin
      // A new strobe wins over a retire in the same cycle.
      pend     <= (pend & ~clr_src) | (req & src_en);
      nmi_q    <= nmi_in;
      nmi_pend <= (nmi_pend & ~clr_nmi) | nmi_rise;
    end
  end

endmodule

// File: rtl/ivp_ffs.sv
module ivp_ffs #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     bits,
  output logic             found,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (bits[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/ivp_pick.sv
module ivp_pick #(
  parameter int NUM_SRC = 16,
  parameter int IDX_W   = 4
) (
  input  logic [NUM_SRC-1:0] pend,
  input  logic [NUM_SRC-1:0] src_en,
  input  logic [NUM_SRC-1:0] lvl_src,
  input  logic               mask_i,
  input  logic               mask_ui,
  output logic               hit,
  output logic [IDX_W-1:0]   hit_idx
);

  logic               acc_hi, acc_lo;
  logic [NUM_SRC-1:0] cand [2];
  logic [1:0]         lane_hit;
  logic [IDX_W-1:0]   lane_idx [2];

  assign acc_hi  = ~(mask_i & mask_ui);
  assign acc_lo  = ~mask_i;
  assign cand[1] = pend & src_en & lvl_src  & {NUM_SRC{acc_hi}};
  assign cand[0] = pend & src_en & ~lvl_src & {NUM_SRC{acc_lo}};

  for (genvar l = 0; l < 2; l++) begin : g_lane
    ivp_ffs #(.N(NUM_SRC), .IDX_W(IDX_W)) u_ffs (
      .bits  (cand[l]),
      .found (lane_hit[l]),
      .idx   (lane_idx[l])
    );
  end

  assign hit     = |lane_hit;
  assign hit_idx = lane_hit[1] ? lane_idx[1] : lane_idx[0];

endmodule

// File: rtl/ivp_out.sv
module ivp_out
  import irq_vec_pkg::*;
#(
  parameter int NUM_SRC  = 16,
  parameter int IDX_W    = 4,
  parameter int VEC_W    = 8,
  parameter int ADDR_W   = 10,
  parameter int LEG_BASE = 16,
  parameter int EXT_BASE = 64,
  parameter int NMI_VEC  = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               nmi_pend,
  input  logic               hit,
  input  logic [IDX_W-1:0]   hit_idx,
  input  logic               ext_map,
  input  logic               ack,
  output logic [NUM_SRC-1:0] clr_src,
  output logic               clr_nmi,
  output logic               valid,
  output logic [VEC_W-1:0]   vec,
  output logic [ADDR_W-1:0]  addr
);

  sel_kind_t        kind_q;
  logic [IDX_W-1:0] idx_q;
  logic             retire;
  logic [VEC_W-1:0] src_vec;

  assign retire  = valid & ack;
  assign src_vec = ext_map ? VEC_W'(EXT_BASE) + VEC_W'(hit_idx)
                           : VEC_W'(LEG_BASE) + VEC_W'(hit_idx);
  assign clr_nmi = retire & (kind_q == SEL_NMI);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_clr
    assign clr_src[i] = retire & (kind_q == SEL_SRC) & (idx_q == IDX_W'(i));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid  <= 1'b0;
      vec    <= '0;
      addr   <= '0;
      kind_q <= SEL_NONE;
      idx_q  <= '0;
    end else if (retire) begin
      valid  <= 1'b0;
      kind_q <= SEL_NONE;
    end else if (!valid) begin
      if (nmi_pend) begin
        valid  <= 1'b1;
        kind_q <= SEL_NMI;
        vec    <= VEC_W'(NMI_VEC);
        addr   <= {VEC_W'(NMI_VEC), 2'b00};
      end else if (hit) begin
        valid  <= 1'b1;
        kind_q <= SEL_SRC;
        idx_q  <= hit_idx;
        vec    <= src_vec;
        addr   <= {src_vec, 2'b00};
      end
    end
  end

endmodule

// File: rtl/irq_vec_prio.sv
module irq_vec_prio
  import irq_vec_pkg::*;
#(
  parameter int           NUM_SRC  = 16,
  parameter int           GRP_SIZE = 2,
  parameter int           VEC_W    = 8,
  parameter int           LEG_SRC  = 12,
  parameter int           LEG_BASE = 16,
  parameter int           EXT_BASE = 64,
  parameter int           NMI_VEC  = 7,
  parameter logic [15:0]  RSV_MAP  = 16'h0200,
  localparam int          NUM_GRP  = NUM_SRC / GRP_SIZE,
  localparam int          IDX_W    = $clog2(NUM_SRC),
  localparam int          ADDR_W   = VEC_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_req,
  input  logic               nmi_in,
  input  logic [NUM_GRP-1:0] grp_level,
  input  logic               mask_i,
  input  logic               mask_ui,
  input  logic               ext_map,
  input  logic               irq_ack,
  output logic               irq_valid,
  output logic [VEC_W-1:0]   irq_vec,
  output logic [ADDR_W-1:0]  irq_addr
);

  logic [NUM_SRC-1:0] src_en;
  logic [NUM_SRC-1:0] lvl_src;
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] clr_src;
  logic               nmi_pend;
  logic               clr_nmi;
  logic               hit;
  logic [IDX_W-1:0]   hit_idx;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign src_en[i]  = slot_live(i, ext_map, LEG_SRC, RSV_MAP[i]);
    assign lvl_src[i] = grp_level[i / GRP_SIZE];
  end

  ivp_pend #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (irq_req),
    .src_en   (src_en),
    .nmi_in   (nmi_in),
    .clr_src  (clr_src),
    .clr_nmi  (clr_nmi),
    .pend     (pend),
    .nmi_pend (nmi_pend)
  );

  ivp_pick #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_pick (
    .pend    (pend),
    .src_en  (src_en),
    .lvl_src (lvl_src),
    .mask_i  (mask_i),
    .mask_ui (mask_ui),
    .hit     (hit),
    .hit_idx (hit_idx)
  );

  ivp_out #(
    .NUM_SRC  (NUM_SRC),
    .IDX_W    (IDX_W),
    .VEC_W    (VEC_W),
    .ADDR_W   (ADDR_W),
    .LEG_BASE (LEG_BASE),
    .EXT_BASE (EXT_BASE),
    .NMI_VEC  (NMI_VEC)
  ) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .nmi_pend (nmi_pend),
    .hit      (hit),
    .hit_idx  (hit_idx),
    .ext_map  (ext_map),
    .ack      (irq_ack),
    .clr_src  (clr_src),
    .clr_nmi  (clr_nmi),
    .valid    (irq_valid),
    .vec      (irq_vec),
    .addr     (irq_addr)
  );

endmodule

// File: rtl/ivp_chk.sv
module ivp_chk #(
  parameter int          NUM_SRC  = 16,
  parameter int          VEC_W    = 8,
  parameter int          LEG_SRC  = 12,
  parameter int          LEG_BASE = 16,
  parameter int          EXT_BASE = 64,
  parameter int          NMI_VEC  = 7,
  parameter logic [15:0] RSV_MAP  = 16'h0200
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mask_i,
  input logic             mask_ui,
  input logic             ext_map,
  input logic             irq_ack,
  input logic             irq_valid,
  input logic [VEC_W-1:0] irq_vec
);

  function automatic logic is_rsv(input logic [VEC_W-1:0] v);
    logic r;
    r = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (RSV_MAP[i] && (v == VEC_W'(LEG_BASE + i) || v == VEC_W'(EXT_BASE + i)))
        r = 1'b1;
    end
    return r;
  endfunction

  // R8
  hold_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid && !irq_ack |=> irq_valid && $stable(irq_vec));

  // R8
  retire_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid && irq_ack |=> !irq_valid);

  // R6
  full_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_valid && mask_i && mask_ui |=> !irq_valid || irq_vec == VEC_W'(NMI_VEC));

  // R1
  vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> irq_vec == VEC_W'(NMI_VEC) || irq_vec >= VEC_W'(LEG_BASE));

  // R10
  compact_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_valid && !ext_map |=> !irq_valid || irq_vec < VEC_W'(LEG_BASE + LEG_SRC));

  // R9
  reserved_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> !is_rsv(irq_vec));

endmodule

bind irq_vec_prio ivp_chk #(
  .NUM_SRC  (NUM_SRC),
  .VEC_W    (VEC_W),
  .LEG_SRC  (LEG_SRC),
  .LEG_BASE (LEG_BASE),
  .EXT_BASE (EXT_BASE),
  .NMI_VEC  (NMI_VEC),
  .RSV_MAP  (RSV_MAP)
) u_ivp_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mask_i    (mask_i),
  .mask_ui   (mask_ui),
  .ext_map   (ext_map),
  .irq_ack   (irq_ack),
  .irq_valid (irq_valid),
  .irq_vec   (irq_vec)
);

// File: tb/irq_vec_prio_test.sv
module irq_vec_prio_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq_req = '0;
  logic        nmi_in = 1'b0;
  logic [7:0]  grp_level = '0;
  logic        mask_i = 1'b0;
  logic        mask_ui = 1'b0;
  logic        ext_map = 1'b0;
  logic        irq_ack;
  logic        mon_ack = 1'b0;
  logic        drv_ack = 1'b0;
  logic        auto_ack = 1'b1;
  logic        irq_valid;
  logic [7:0]  irq_vec;
  logic [9:0]  irq_addr;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  typedef struct { int vec; string tag; } exp_t;
  exp_t expq[$];

  assign irq_ack = mon_ack | drv_ack;

  always #2 clk = ~clk;

  irq_vec_prio uut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .nmi_in(nmi_in),
    .grp_level(grp_level), .mask_i(mask_i), .mask_ui(mask_ui),
    .ext_map(ext_map), .irq_ack(irq_ack), .irq_valid(irq_valid),
    .irq_vec(irq_vec), .irq_addr(irq_addr)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input int vec, input string tag);
    exp_t e;
    e.vec = vec;
    e.tag = tag;
    expq.push_back(e);
  endtask

  task automatic strobe(input logic [15:0] m);
    irq_req = m;
    @(negedge clk);
    irq_req = '0;
  endtask

  task automatic nmi_pulse();
    nmi_in = 1'b1;
    @(negedge clk);
    nmi_in = 1'b0;
  endtask

  task automatic settle();
    while (expq.size() != 0) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  function automatic int vmap(input logic ext, input int i);
    return ext ? 64 + i : 16 + i;
  endfunction

  // Monitor: pops the scoreboard on every offer and acknowledges it.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && auto_ack && irq_valid) begin
        if (expq.size() == 0) begin
          check(0, "unexpected offer (R6/R9/R10)", irq_vec, -1);
        end else begin
          exp_t e;
          e = expq.pop_front();
          check(irq_vec == 8'(e.vec), e.tag, irq_vec, e.vec);
          check(irq_addr == 10'(e.vec * 4), {e.tag, " addr R1"}, irq_addr, e.vec * 4);
        end
        mon_ack = 1'b1;
        @(negedge clk);
        mon_ack = 1'b0;
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check(irq_valid == 0, "R11 valid after reset", irq_valid, 0);
    check(irq_vec == 0 && irq_addr == 0, "R11 vector after reset", irq_vec, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(irq_valid == 0, "R11 nothing pending", irq_valid, 0);

    // R6 both masks: nothing offered; R7 + R4 order after opening
    mask_i = 1; mask_ui = 1;
    strobe(16'h0029);  // sources 0,3,5
    repeat (8) @(negedge clk);
    check(irq_valid == 0, "R6 full mask blocks", irq_valid, 0);
    push(16, "R4 src0"); push(19, "R4 src3"); push(21, "R4 src5");
    mask_i = 0; mask_ui = 0;
    settle();

    // R3 + R5: group 2 (sources 4,5) at level 1
    mask_i = 1; mask_ui = 1;
    grp_level = 8'b0000_0100;
    strobe(16'h0032);  // sources 1,4,5
    push(20, "R3/R5 src4 first"); push(21, "R5 src5 then"); push(17, "R3 src1 last");
    mask_i = 0; mask_ui = 0;
    settle();

    // R6 only level 1 accepted; R7 released after mask change
    grp_level = 8'b0000_0010;  // sources 2,3
    mask_i = 1; mask_ui = 1;
    strobe(16'h0009);  // sources 0,3
    push(19, "R6 level1 only");
    mask_ui = 0;
    settle();
    check(irq_valid == 0, "R6 level0 held back", irq_valid, 0);
    push(16, "R7 released");
    mask_i = 0;
    settle();

    // R2 NMI through full mask and ahead of level 1
    mask_i = 1; mask_ui = 1;
    strobe(16'h0008);  // source 3 (level 1)
    push(7, "R2 nmi first");
    nmi_pulse();
    settle();
    push(19, "R2 maskable after nmi");
    mask_i = 0; mask_ui = 0;
    settle();
    grp_level = '0;

    // R9 reserved slot, R10 compact map ignores high sources
    strobe(16'h0200);
    repeat (8) @(negedge clk);
    check(irq_valid == 0, "R9 reserved slot", irq_valid, 0);
    strobe(16'h2000);  // source 13, compact map
    repeat (8) @(negedge clk);
    check(irq_valid == 0, "R10 compact ignores src13", irq_valid, 0);
    ext_map = 1;
    push(vmap(1, 13), "R1 ext src13");
    strobe(16'h2000);
    settle();
    push(vmap(1, 0), "R1 ext src0");
    strobe(16'h0001);
    settle();
    ext_map = 0;

    // R8 hold without acknowledge; ack while idle ignored
    drv_ack = 1;
    @(negedge clk);
    drv_ack = 0;
    auto_ack = 0;
    strobe(16'h0004);  // source 2
    repeat (3) @(negedge clk);
    check(irq_valid == 1 && irq_vec == 18, "R8 offer after idle ack", irq_vec, 18);
    nmi_pulse();
    repeat (5) @(negedge clk);
    check(irq_valid == 1 && irq_vec == 18, "R8 held against nmi", irq_vec, 18);
    push(7, "R8 nmi after retire");
    drv_ack = 1;
    @(negedge clk);
    drv_ack = 0;
    check(irq_valid == 0, "R8 valid drops after ack", irq_valid, 0);
    auto_ack = 1;
    settle();

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule